// File: doc/BRIEF.md
# Dual-Style Parallel Host Bus Slave

This block lets an external microprocessor reach a bank of 32 eight-bit registers over a parallel bus. Two handshake styles are supported, chosen by a static input. The split-strobe style has separate active-low read and write strobes and a ready output that holds the host in wait states. The direction-strobe style has one active-low data strobe, a read/write direction line and an active-low acknowledge output. Either style can take its address from a dedicated 5-bit address bus, or from the low five lines of a shared address/data bus that an active-low address strobe qualifies.

All pad inputs go through a register pipeline of `SYNC_STAGES` clock stages. Strobe edges are detected at the end of this pipeline. The pipeline delays address and data by the same number of stages, so each value is taken as it stood at the pad at the moment of the edge. After a strobe starts, the block waits a fixed number of clocks before it signals completion. The tri-state data pads appear as a data output together with an output enable.

Top module: `mpu_bus_slave`

## Requirements
- R1: After reset, `rdy_o` is 1, `ack_n_o` is 1 and `data_oe_o` is 0, and every register reads back as 0.
- R2: In split-strobe style (`bus_style_i`=0), the byte on the data lines at the rising edge of `wr_n_i` is stored at the cycle's address.
- R3: In split-strobe style, a cycle with `rd_n_i` low drives the addressed register onto `data_o` with `data_oe_o`=1 by the time `rdy_o` rises.
- R4: In split-strobe style, `rdy_o` goes low combinationally when a strobe falls. It rises on the clock edge that is SYNC_STAGES+1+ACC_LAT edges after the first edge that samples the strobe low (5 edges with defaults), and then stays high.
- R5: In direction-strobe style (`bus_style_i`=1) with `rw_i`=0, the byte on the data lines at the rising edge of `ds_n_i` is stored at the cycle's address.
- R6: In direction-strobe style with `rw_i`=1, the addressed register is driven on `data_o` with `data_oe_o`=1 when `ack_n_o` falls.
- R7: In direction-strobe style, `ack_n_o` stays high through the wait period and goes low at the same edge count as R4. It then stays low until `ds_n_i` rises. In that style `rdy_o` stays 1. In split-strobe style `ack_n_o` stays 1.
- R8: With the dedicated address bus (`mux_mode_i`=0), the address is the value of `addr_i` when the strobe falls. Changes to `addr_i` later in the cycle have no effect.
- R9: In shared-bus mode (`mux_mode_i`=1), the address is `data_i[4:0]` at the falling edge of `as_n_i`. `data_i[7:5]` and `addr_i` are ignored.
- R10: `data_oe_o` is 1 only while a read cycle is in progress and its read strobe is still asserted. It drops in the same instant that the strobe is released.
- R11: The wait period lasts exactly ACC_LAT clocks (default 2) after the strobe edge has been detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_style_i | input | 1 | 0 = split read/write strobes with ready, 1 = data strobe with direction and acknowledge |
| mux_mode_i | input | 1 | 0 = dedicated address bus, 1 = address on shared data lines |
| addr_i | input | 5 | Dedicated address bus |
| as_n_i | input | 1 | Address strobe for shared-bus mode, active low |
| rd_n_i | input | 1 | Read strobe, split style, active low |
| wr_n_i | input | 1 | Write strobe, split style, active low |
| ds_n_i | input | 1 | Data strobe, direction style, active low |
| rw_i | input | 1 | Direction line, 1 = read, 0 = write |
| data_i | input | 8 | Data pads (inbound), also the address in shared-bus mode |
| data_o | output | 8 | Data pads (outbound) |
| data_oe_o | output | 1 | Enable for the outbound data pads |
| rdy_o | output | 1 | Ready, split style; low requests wait states |
| ack_n_o | output | 1 | Acknowledge, direction style, active low |

## Verification
The assertions assume a well-behaved host. It holds each strobe low until completion is signalled, and it leaves the bus idle for at least SYNC_STAGES+1 clocks between cycles. It never asserts both split strobes together, and in shared-bus mode it drops the address strobe at least two clocks before the data strobe. The bench produces only such cycles. Every strobe change happens on a falling clock edge, the bench waits five idle clocks between cycles, and address or data lines change only at points where the pipeline alignment makes the change safe.

// File: rtl/mpu_bus_pkg.sv
package mpu_bus_pkg;

    localparam int AW          = 5;
    localparam int DW          = 8;
    localparam int DEPTH       = 1 << AW;
    localparam int SYNC_STAGES = 2;
    localparam int ACC_LAT     = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DONE = 2'd2
    } cyc_state_e;

    typedef struct packed {
        logic          is_read;
        logic [AW-1:0] addr;
    } cyc_info_t;

    typedef struct packed {
        logic          as_n;
        logic          rd_n;
        logic          wr_n;
        logic          ds_n;
        logic          rw;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } pad_bundle_t;

    localparam int PAD_W = $bits(pad_bundle_t);

    localparam pad_bundle_t PAD_IDLE = '{
        as_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1, ds_n: 1'b1, rw: 1'b1,
        addr: '0, data: '0
    };

    function automatic logic went_low(input logic prev_n, input logic cur_n);
        return prev_n & ~cur_n;
    endfunction

    function automatic logic went_high(input logic prev, input logic cur);
        return ~prev & cur;
    endfunction

endpackage

// File: rtl/mbs_pad_pipe.sv
module mbs_pad_pipe #(
    parameter int             W       = 8,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= RST_VAL;
                    else     stage_q[s] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= RST_VAL;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/mbs_regfile.sv
module mbs_regfile
    import mpu_bus_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem[raddr_i];

    // R2
    commit_chk: assert property (@(posedge clk) disable iff (rst)
        we_i |=> (mem[$past(waddr_i)] == $past(wdata_i)));

endmodule

// File: rtl/mbs_cycle_ctrl.sv
module mbs_cycle_ctrl
    import mpu_bus_pkg::*;
#(
    parameter int LAT = ACC_LAT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          style_i,
    input  logic          mux_i,
    input  pad_bundle_t   pad_s_i,
    output cyc_state_e    state_o,
    output cyc_info_t     cyc_o,
    output logic          we_o,
    output logic [AW-1:0] waddr_o,
    output logic [DW-1:0] wdata_o
);

    localparam int CW = (LAT < 2) ? 1 : $clog2(LAT + 1);

    cyc_state_e    state_q;
    cyc_info_t     cyc_q;
    logic [CW-1:0] cnt_q;
    logic          act_prev_q;
    logic          as_prev_q;
    logic [AW-1:0] mux_addr_q;

    logic active_s, read_s, start_s, end_s, as_fall;
    logic [AW-1:0] start_addr;

    always_comb begin
        if (style_i) begin
            active_s = ~pad_s_i.ds_n;
            read_s   = pad_s_i.rw;
        end else begin
            active_s = ~pad_s_i.rd_n | ~pad_s_i.wr_n;
            read_s   = ~pad_s_i.rd_n;
        end
        start_s    = went_high(act_prev_q, active_s);
        end_s      = act_prev_q & ~active_s;
        as_fall    = mux_i & went_low(as_prev_q, pad_s_i.as_n);
        start_addr = mux_i ? mux_addr_q : pad_s_i.addr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            cyc_q      <= '0;
            cnt_q      <= '0;
            act_prev_q <= 1'b0;
            as_prev_q  <= 1'b1;
            mux_addr_q <= '0;
            we_o       <= 1'b0;
            waddr_o    <= '0;
            wdata_o    <= '0;
        end else begin
            act_prev_q <= active_s;
            as_prev_q  <= pad_s_i.as_n;
            we_o       <= 1'b0;
            if (as_fall) mux_addr_q <= pad_s_i.data[AW-1:0];
            case (state_q)
                ST_IDLE: begin
                    if (start_s) begin
                        state_q       <= ST_WAIT;
                        cnt_q         <= CW'(LAT - 1);
                        cyc_q.is_read <= read_s;
                        cyc_q.addr    <= start_addr;
                    end
                end
                ST_WAIT: begin
                    if (end_s)              state_q <= ST_IDLE;
                    else if (cnt_q == '0)   state_q <= ST_DONE;
                    else                    cnt_q   <= cnt_q - 1'b1;
                end
                ST_DONE: begin
                    if (end_s) begin
                        state_q <= ST_IDLE;
                        if (!cyc_q.is_read) begin
                            we_o    <= 1'b1;
                            waddr_o <= cyc_q.addr;
                            wdata_o <= pad_s_i.data;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign state_o = state_q;
    assign cyc_o   = cyc_q;

    // R11
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DONE && $past(state_q) != ST_DONE)
            |-> ($past(state_q) == ST_WAIT && $past(cnt_q) == '0));

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |-> $stable(cyc_q.addr));

endmodule

// File: rtl/mpu_bus_slave.sv
module mpu_bus_slave
    import mpu_bus_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_style_i,
    input  logic          mux_mode_i,
    input  logic [4:0]    addr_i,
    input  logic          as_n_i,
    input  logic          rd_n_i,
    input  logic          wr_n_i,
    input  logic          ds_n_i,
    input  logic          rw_i,
    input  logic [7:0]    data_i,
    output logic [7:0]    data_o,
    output logic          data_oe_o,
    output logic          rdy_o,
    output logic          ack_n_o
);

    pad_bundle_t   pad_raw, pad_s;
    cyc_state_e    state;
    cyc_info_t     cyc;
    logic          we;
    logic [AW-1:0] waddr;
    logic [DW-1:0] wdata, rdata;
    logic          raw_act, raw_read;

    always_comb begin
        pad_raw.as_n = as_n_i;
        pad_raw.rd_n = rd_n_i;
        pad_raw.wr_n = wr_n_i;
        pad_raw.ds_n = ds_n_i;
        pad_raw.rw   = rw_i;
        pad_raw.addr = addr_i;
        pad_raw.data = data_i;
    end

    mbs_pad_pipe #(
        .W       (PAD_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PAD_IDLE)
    ) i_pipe (
        .clk (clk),
        .rst (rst),
        .d_i (pad_raw),
        .q_o (pad_s)
    );

    mbs_cycle_ctrl #(
        .LAT (ACC_LAT)
    ) i_ctrl (
        .clk     (clk),
        .rst     (rst),
        .style_i (bus_style_i),
        .mux_i   (mux_mode_i),
        .pad_s_i (pad_s),
        .state_o (state),
        .cyc_o   (cyc),
        .we_o    (we),
        .waddr_o (waddr),
        .wdata_o (wdata)
    );

    mbs_regfile i_regs (
        .clk     (clk),
        .rst     (rst),
        .we_i    (we),
        .waddr_i (waddr),
        .wdata_i (wdata),
        .raddr_i (cyc.addr),
        .rdata_o (rdata)
    );

    always_comb begin
        if (bus_style_i) begin
            raw_act  = ~ds_n_i;
            raw_read = ~ds_n_i & rw_i;
        end else begin
            raw_act  = ~rd_n_i | ~wr_n_i;
            raw_read = ~rd_n_i;
        end
        data_oe_o = (state != ST_IDLE) & cyc.is_read & raw_read;
        data_o    = data_oe_o ? rdata : '0;
        rdy_o     = bus_style_i | ~(raw_act & (state != ST_DONE));
        ack_n_o   = ~bus_style_i ? 1'b1 : ~(raw_act & (state == ST_DONE));
    end

    // R3
    read_data_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (data_oe_o && $past(data_oe_o) && !we) |-> $stable(data_o));

    // R7
    ack_release_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(ack_n_o) && bus_style_i) |-> ds_n_i);

endmodule

// File: tb/test_mpu_bus_slave.sv
module test_mpu_bus_slave;

    localparam int SYNC = 2;
    localparam int LAT  = 2;
    localparam int TOT  = SYNC + 1 + LAT;

    logic       clk = 1'b0;
    logic       rst;
    logic       bus_style_i, mux_mode_i;
    logic [4:0] addr_i;
    logic       as_n_i, rd_n_i, wr_n_i, ds_n_i, rw_i;
    logic [7:0] data_i;
    logic [7:0] data_o;
    logic       data_oe_o, rdy_o, ack_n_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] sb [32];

    always #2.5 clk = ~clk;

    mpu_bus_slave i_mpu_bus_slave (
        .clk         (clk),
        .rst         (rst),
        .bus_style_i (bus_style_i),
        .mux_mode_i  (mux_mode_i),
        .addr_i      (addr_i),
        .as_n_i      (as_n_i),
        .rd_n_i      (rd_n_i),
        .wr_n_i      (wr_n_i),
        .ds_n_i      (ds_n_i),
        .rw_i        (rw_i),
        .data_i      (data_i),
        .data_o      (data_o),
        .data_oe_o   (data_oe_o),
        .rdy_o       (rdy_o),
        .ack_n_o     (ack_n_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_bus();
        as_n_i = 1'b1; rd_n_i = 1'b1; wr_n_i = 1'b1; ds_n_i = 1'b1; rw_i = 1'b1;
    endtask

    // One complete host cycle, handshake checked on every clock.
    task automatic host_cycle(input bit is_wr, input logic [4:0] a,
                              input logic [7:0] wd, input logic [2:0] junk);
        bit style = bus_style_i;
        @(negedge clk);
        if (mux_mode_i) begin
            data_i = {junk, a};
            addr_i = ~a;                 // R9: dedicated bus ignored
            as_n_i = 1'b0;
            @(negedge clk);
            data_i = is_wr ? wd : 8'h00;
            @(negedge clk);
        end else begin
            addr_i = a;
            data_i = is_wr ? wd : 8'h00;
        end
        if (style) begin
            rw_i = ~is_wr; ds_n_i = 1'b0;
        end else if (is_wr) begin
            wr_n_i = 1'b0;
        end else begin
            rd_n_i = 1'b0;
        end
        for (int k = 1; k <= TOT; k++) begin
            @(negedge clk);
            if (!mux_mode_i && k == 2) addr_i = ~a;   // R8: late change ignored
            if (style) begin
                chk(rdy_o == 1'b1, "R7 rdy idle in strobe style", rdy_o, 1);
                chk(ack_n_o == (k < TOT), "R7 ack timing", ack_n_o, (k < TOT));
            end else begin
                chk(ack_n_o == 1'b1, "R7 ack idle in split style", ack_n_o, 1);
                chk(rdy_o == (k >= TOT), "R4 R11 rdy timing", rdy_o, (k >= TOT));
            end
        end
        if (is_wr) begin
            chk(data_oe_o == 1'b0, "R10 no drive on write", data_oe_o, 0);
        end else begin
            chk(data_oe_o == 1'b1, style ? "R6 read enable" : "R3 read enable", data_oe_o, 1);
            chk(data_o == sb[a], style ? "R6 R8 R9 read data" : "R3 R8 R9 read data",
                data_o, sb[a]);
        end
        @(negedge clk);
        idle_bus();
        #1;
        chk(data_oe_o == 1'b0, "R10 release on strobe rise", data_oe_o, 0);
        chk(rdy_o == 1'b1 && ack_n_o == 1'b1, "R4 R7 handshake release",
            {rdy_o, ack_n_o}, 2'b11);
        if (is_wr) sb[a] = wd;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        bus_style_i = 1'b0; mux_mode_i = 1'b0;
        addr_i = '0; data_i = '0;
        idle_bus();
        for (int i = 0; i < 32; i++) sb[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(rdy_o == 1'b1, "R1 reset rdy", rdy_o, 1);
        chk(ack_n_o == 1'b1, "R1 reset ack", ack_n_o, 1);
        chk(data_oe_o == 1'b0, "R1 reset oe", data_oe_o, 0);
        // R1: every register reads zero
        for (int a = 0; a < 32; a++) host_cycle(1'b0, 5'(a), 8'h00, 3'b000);

        for (int m = 0; m < 4; m++) begin
            bus_style_i = m[1];
            mux_mode_i  = m[0];
            repeat (3) @(negedge clk);
            // R2 R5: write every address, R9 with junk upper lines
            for (int a = 0; a < 32; a++)
                host_cycle(1'b1, 5'(a), 8'((a * 29 + m * 71 + 13) & 255), 3'(a + m));
            // R3 R6: read every address back
            for (int a = 0; a < 32; a++)
                host_cycle(1'b0, 5'(31 - a), 8'h00, 3'(7 - a));
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule